// File: doc/BRIEF.md
# Three-Wire Addressed Control Port

This block receives control words for a telephone line-interface front end over a three-wire, write-only serial link. The link has a serial clock, a serial data line and an active-high enable. While the enable is high, each rising edge of the serial clock moves one data bit into a shift register. When the enable drops, the block looks at the last eight bits it received. The top bit of that frame chooses one of two seven-bit control registers, and the seven bits below it become that register's new contents.

The stored fields drive parallel control lines: the hookswitch driver, two general logic outputs, the DC characteristic choice, low-drop dialing, gain-control range and ratio, mute and +6 dB boost for each speech direction, and a single-hybrid-input mode. One bit holds a factory test mode. It is stored but drives nothing.

The serial lines are asynchronous to the system clock. They pass through two-flop synchronizers, and the block finds their edges in the system clock domain. The supply-drop monitor appears as the reset input.

Top module: `ser_ctl_port`

## Requirements
- R1: While the synchronized enable is low, serial clock and data activity has no effect. A frame of fewer than eight bits sent right after such activity is still discarded.
- R2: Data is sampled on the rising edge of the serial clock, most significant bit first. The eighth bit received last becomes frame bit 0.
- R3: When the enable falls after more than eight clock edges, only the final eight bits count. All earlier bits are dropped.
- R4: Frame bit 7 selects the target register: 0 writes the first register and 1 writes the second. The register that is not selected keeps its value.
- R5: In the first register, payload bit 0 drives hook_o, bit 1 drives out1_o, bit 2 drives out2_o, bit 4 drives dc_curr_o and bit 5 drives dial_o.
- R6: In the second register, payload bit 0 drives agc_off_o, bit 1 drives agc_ratio_o, bit 2 drives tx_mute_o, bit 3 drives rx_mute_o, bit 4 drives tx_boost_o, bit 5 drives rx_boost_o and bit 6 drives single_hyb_o.
- R7: A frame that ends with fewer than eight clock edges leaves both registers unchanged.
- R8: All outputs are 0 after reset, and asserting rst_n low at any time clears every stored bit.
- R9: First-register payload bit 6 (test mode) and bit 3 (spare) are stored but change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset from the supply-drop monitor |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_en | input | 1 | Serial enable, active high, asynchronous |
| hook_o | output | 1 | Hookswitch drive |
| out1_o | output | 1 | General logic output 1 |
| out2_o | output | 1 | General logic output 2 |
| dc_curr_o | output | 1 | 1 selects the current-regulating DC characteristic |
| dial_o | output | 1 | Low-voltage-drop dialing mode |
| agc_off_o | output | 1 | Disables the gain-control range |
| agc_ratio_o | output | 1 | Selects the alternate gain-control start/stop ratio |
| tx_mute_o | output | 1 | Transmit path mute |
| rx_mute_o | output | 1 | Receive path mute |
| tx_boost_o | output | 1 | Transmit +6 dB gain |
| rx_boost_o | output | 1 | Receive +6 dB gain |
| single_hyb_o | output | 1 | Receive from the short-line hybrid input only |

## Verification
The assertions assume that each serial level stays put for at least three system clocks, so the synchronizers never miss an edge. They also assume that data is stable before and after each rising serial clock edge, and that the enable never falls in the same system cycle as a serial clock rise. The bench meets these assumptions by holding data for several system clocks around each rising edge, keeping each serial half-period at three or more system clocks, and waiting after the last clock before it drops the enable.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
    localparam int FRAME_W = 8;
    localparam int PAY_W   = FRAME_W - 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    // first register field positions
    localparam int A_HOOK  = 0;
    localparam int A_OUT1  = 1;
    localparam int A_OUT2  = 2;
    localparam int A_DCSEL = 4;
    localparam int A_DIAL  = 5;

    // second register field positions
    localparam int B_AGCOFF = 0;
    localparam int B_RATIO  = 1;
    localparam int B_TXMUTE = 2;
    localparam int B_RXMUTE = 3;
    localparam int B_TXBST  = 4;
    localparam int B_RXBST  = 5;
    localparam int B_SHYB   = 6;

    typedef struct packed {
        logic hook;
        logic out1;
        logic out2;
        logic dc_curr;
        logic dial;
        logic agc_off;
        logic agc_ratio;
        logic tx_mute;
        logic rx_mute;
        logic tx_boost;
        logic rx_boost;
        logic single_hyb;
    } ctl_fields_t;
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb pipe_d[0] = async_i;
        end else begin : g_many
            always_comb begin
                pipe_d[0] = async_i;
                for (int s = 1; s < STAGES; s++) pipe_d[s] = pipe_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/serctl_shifter.sv
module serctl_shifter
    import serctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               dat_s,
    input  logic               en_s,
    output logic               commit_o,
    output logic [FRAME_W-1:0] frame_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
        logic               clk_p;
        logic               en_p;
    } shf_t;

    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    shf_t st_d, st_q;
    logic rise, fall;

    always_comb begin
        st_d       = st_q;
        rise       = sclk_s & ~st_q.clk_p;
        fall       = st_q.en_p & ~en_s;
        st_d.clk_p = sclk_s;
        st_d.en_p  = en_s;
        if (en_s) begin
            if (rise) begin
                st_d.sh = {st_q.sh[FRAME_W-2:0], dat_s};
                if (st_q.cnt != FULL) st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
        commit_o = fall && (st_q.cnt == FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_o = st_q.sh;

    // R1: no shifting while the enable is low
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> $stable(st_q.sh));

    // R2: the newest bit enters at the bottom on a rising serial clock
    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && rise) |=> (st_q.sh[0] == $past(dat_s)));
endmodule

// File: rtl/serctl_regs.sv
module serctl_regs
    import serctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] frame,
    output ctl_fields_t        fields_o
);
    typedef struct packed {
        logic [PAY_W-1:0] ra;
        logic [PAY_W-1:0] rb;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            if (frame[FRAME_W-1]) rg_d.rb = frame[PAY_W-1:0];
            else                  rg_d.ra = frame[PAY_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    // test and spare bits of the first register stay internal
    always_comb begin
        fields_o.hook       = rg_q.ra[A_HOOK];
        fields_o.out1       = rg_q.ra[A_OUT1];
        fields_o.out2       = rg_q.ra[A_OUT2];
        fields_o.dc_curr    = rg_q.ra[A_DCSEL];
        fields_o.dial       = rg_q.ra[A_DIAL];
        fields_o.agc_off    = rg_q.rb[B_AGCOFF];
        fields_o.agc_ratio  = rg_q.rb[B_RATIO];
        fields_o.tx_mute    = rg_q.rb[B_TXMUTE];
        fields_o.rx_mute    = rg_q.rb[B_RXMUTE];
        fields_o.tx_boost   = rg_q.rb[B_TXBST];
        fields_o.rx_boost   = rg_q.rb[B_RXBST];
        fields_o.single_hyb = rg_q.rb[B_SHYB];
    end

    // R4: nothing moves without a commit
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rg_q));

    // R4: address bit 1 leaves the first register alone
    p_sel_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && frame[FRAME_W-1]) |=> $stable(rg_q.ra));

    // R5 / R9: address bit 0 stores the full payload, spare and test bits included
    p_load_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !frame[FRAME_W-1]) |=> (rg_q.ra == $past(frame[PAY_W-1:0])));
endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port
    import serctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_dat,
    input  logic ser_en,
    output logic hook_o,
    output logic out1_o,
    output logic out2_o,
    output logic dc_curr_o,
    output logic dial_o,
    output logic agc_off_o,
    output logic agc_ratio_o,
    output logic tx_mute_o,
    output logic rx_mute_o,
    output logic tx_boost_o,
    output logic rx_boost_o,
    output logic single_hyb_o
);
    logic [2:0]         lines_s;
    logic               commit;
    logic [FRAME_W-1:0] frame;
    ctl_fields_t        fields;

    serctl_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_en, ser_dat, ser_clk}),
        .sync_o  (lines_s)
    );

    serctl_shifter u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (lines_s[0]),
        .dat_s    (lines_s[1]),
        .en_s     (lines_s[2]),
        .commit_o (commit),
        .frame_o  (frame)
    );

    serctl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit),
        .frame    (frame),
        .fields_o (fields)
    );

    assign hook_o       = fields.hook;
    assign out1_o       = fields.out1;
    assign out2_o       = fields.out2;
    assign dc_curr_o    = fields.dc_curr;
    assign dial_o       = fields.dial;
    assign agc_off_o    = fields.agc_off;
    assign agc_ratio_o  = fields.agc_ratio;
    assign tx_mute_o    = fields.tx_mute;
    assign rx_mute_o    = fields.rx_mute;
    assign tx_boost_o   = fields.tx_boost;
    assign rx_boost_o   = fields.rx_boost;
    assign single_hyb_o = fields.single_hyb;
endmodule

// File: tb/ser_ctl_port_tb.sv
module ser_ctl_port_tb;
    logic clk = 0;
    logic rst_n = 0;
    logic ser_clk = 0, ser_dat = 0, ser_en = 0;
    logic hook_o, out1_o, out2_o, dc_curr_o, dial_o, agc_off_o, agc_ratio_o;
    logic tx_mute_o, rx_mute_o, tx_boost_o, rx_boost_o, single_hyb_o;

    always #10 clk = ~clk;

    ser_ctl_port u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en(ser_en),
        .hook_o(hook_o), .out1_o(out1_o), .out2_o(out2_o), .dc_curr_o(dc_curr_o),
        .dial_o(dial_o), .agc_off_o(agc_off_o), .agc_ratio_o(agc_ratio_o),
        .tx_mute_o(tx_mute_o), .rx_mute_o(rx_mute_o), .tx_boost_o(tx_boost_o),
        .rx_boost_o(rx_boost_o), .single_hyb_o(single_hyb_o)
    );

    typedef struct {
        logic [11:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    logic [6:0] m_a = '0, m_b = '0;

    wire [11:0] got = {single_hyb_o, rx_boost_o, tx_boost_o, rx_mute_o, tx_mute_o,
                       agc_ratio_o, agc_off_o, dial_o, dc_curr_o, out2_o, out1_o, hook_o};

    function automatic logic [11:0] model_vec();
        return {m_b[6], m_b[5], m_b[4], m_b[3], m_b[2], m_b[1], m_b[0],
                m_a[5], m_a[4], m_a[2], m_a[1], m_a[0]};
    endfunction

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            item_t it;
            @(chk_ev);
            @(negedge clk);
            it = q.pop_front();
            n_chk++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %03h expected %03h", it.tag, got, it.exp);
            end
        end
    end

    task automatic expect_now(input string tag);
        item_t it;
        it.exp = model_vec();
        it.tag = tag;
        q.push_back(it);
        -> chk_ev;
        repeat (3) @(posedge clk);
    endtask

    // sends nbits from the bottom of bits, most significant first
    task automatic send_frame(input int nbits, input logic [15:0] bits, input string tag);
        logic [7:0] f;
        ser_en = 1;
        repeat (4) @(posedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            repeat (3) @(posedge clk);
            ser_clk = 1;
            repeat (3) @(posedge clk);
            ser_clk = 0;
            repeat (1) @(posedge clk);
        end
        repeat (4) @(posedge clk);
        ser_en = 0;
        repeat (12) @(posedge clk);
        if (nbits >= 8) begin
            f = bits[7:0];
            if (f[7]) m_b = f[6:0];
            else      m_a = f[6:0];
        end
        expect_now(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        expect_now("R8 reset state");
        rst_n = 1;
        repeat (4) @(posedge clk);
        send_frame(8, 16'h07, "R5 first register hook/out1/out2");
        send_frame(8, 16'hFF, "R6 second register all fields, R4 first kept");
        send_frame(8, 16'h35, "R5 dc_curr/dial mapping, R4 second kept");
        send_frame(8, 16'h95, "R6 alternate second-register pattern");
        send_frame(12, 16'h0F01, "R3 long frame keeps last eight");
        send_frame(5, 16'h16, "R7 short frame discarded");
        // R1: activity with enable low
        for (int k = 0; k < 10; k++) begin
            ser_dat = k[0];
            repeat (3) @(posedge clk);
            ser_clk = 1;
            repeat (3) @(posedge clk);
            ser_clk = 0;
        end
        repeat (6) @(posedge clk);
        expect_now("R1 idle activity ignored");
        send_frame(4, 16'h5, "R1 short frame after idle activity");
        send_frame(8, 16'h48, "R9 test and spare bits drive nothing");
        send_frame(8, 16'h02, "R2 bit order first register");
        send_frame(8, 16'h81, "R2 bit order second register");
        send_frame(9, 16'h1AA, "R3 nine-bit frame");
        send_frame(8, 16'h7F, "R5 all first-register bits set");
        rst_n = 0;
        repeat (2) @(posedge clk);
        m_a = '0;
        m_b = '0;
        expect_now("R8 reset clears registers");
        rst_n = 1;
        repeat (5) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule